// File: doc/BRIEF.md
# I2C Register-File Slave with Time Snapshot

This block is a bus target on a two-wire I2C link that exposes a 64-byte register space. The lowest seven bytes are timekeeping bytes supplied live by a neighbouring counter. Every byte from address 7 upward is local storage: one control byte followed by general-purpose RAM. The bus lines are sampled by a fast system clock through two-flop synchronisers, and START and STOP are recognised from edges in that clock domain. One register pointer serves both directions and advances after every byte.

So that a master reading several time bytes in a row never sees a half-updated value, the block does not read the time bytes directly. It reads a snapshot register, which copies the live time bus on every START, on every STOP, and whenever the pointer steps round to address 0. Every data byte the master writes goes out on a write port, so that the time counter can take writes aimed at its bytes.

A power-good input gates all access. While it is low, and for a fixed number of cycles after it returns, the block answers nothing and writes nothing. The write port is valid-only and has no ready signal. The bus cannot be stalled, because the block does no clock stretching, so the sink must accept every `wr_valid_o` pulse in the cycle it appears.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal SLAVE_ADDR (default 7'h68, binary 1101000). Bit 0 of that byte selects the direction: 0 is a write, 1 is a read. Acknowledge means the block pulls SDA low during the ninth clock. For any other address it gives no acknowledge and keeps SDA released, including on later bytes, until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer from its low ADDR_W bits; the upper bits are ignored. Each later byte is acknowledged, stored at the pointer, and issued as one `wr_valid_o` pulse carrying that address and byte. The pointer then increments.
- R3: A read transfer starts at the current pointer, which keeps its last value across STOP and START when no new pointer was written. Data goes out MSB first, and the pointer increments after every byte sent.
- R4: Reading an address below TIME_BYTES returns the snapshot byte. Byte k is `time_i[8k+7:8k]`. Reading an address from TIME_BYTES upward returns the last byte written there, or 0 after reset.
- R5: The pointer wraps from 2^ADDR_W-1 to 0, in both reads and writes.
- R6: The snapshot reloads from `time_i` on START, on STOP, and when the pointer increments to 0. It holds its value otherwise, so the time bytes of one read stay consistent even while `time_i` changes.
- R7: When the master answers a sent byte with NACK (SDA high in the ninth clock), the block stops driving, leaves SDA released, and accepts the next transfer normally.
- R8: A repeated START returns the block to address matching without disturbing the pointer.
- R9: While `pwr_good_i` is low, and until REC_CYCLES cycles after it goes high again, the block acknowledges nothing, writes nothing and drives nothing. A transfer in flight when power drops is abandoned.
- R10: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a STOP, clock pulses without a new START are ignored.
- R11: During and after reset, SDA is released, `wr_valid_o` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| pwr_good_i | input | 1 | Supply-good indication; low blocks access |
| time_i | input | TIME_BYTES*8 | Live time bytes, byte k at bits 8k+7:8k |
| wr_valid_o | output | 1 | One-cycle pulse for each written data byte |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | 8 | Byte written |

## Verification
The bench keeps the default 6-bit pointer and seven time bytes, which makes the full register space small enough to sweep. One 64-byte write that starts part-way through the space crosses the wrap point, and a 64-byte read from address 0 then covers every location. The recovery time is cut to 400 cycles. At that length an address byte sent straight after power returns falls inside the blocked window, while a later one falls outside it. The address check flips each bit of the target address in turn.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } xfer_st_e;
endpackage

// File: rtl/i2c_rf_sync_edge.sv
module i2c_rf_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] line_raw;
  logic [1:0] now_v;
  logic [1:0] prev_v;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], line_raw[g]};
    end
    assign now_v[g]  = pipe_q[STAGES-1];
    assign prev_v[g] = pipe_q[STAGES];
  end

  assign scl_s     = now_v[0];
  assign sda_s     = now_v[1];
  assign scl_rise  = now_v[0] & ~prev_v[0];
  assign scl_fall  = ~now_v[0] & prev_v[0];
  assign start_det = now_v[0] & prev_v[0] & prev_v[1] & ~now_v[1];
  assign stop_det  = now_v[0] & prev_v[0] & ~prev_v[1] & now_v[1];
endmodule

// File: rtl/i2c_rf_pwr_gate.sv
module i2c_rf_pwr_gate #(
  parameter int REC_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  output logic acc_ok
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(REC_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!pwr_good_i)    cnt_q <= '0;
    else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign acc_ok = pwr_good_i && (cnt_q == CNT_END);
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
  parameter int ADDR_W     = 6,
  parameter int TIME_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snap_en,
  input  logic [TIME_BYTES*8-1:0] time_i,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  localparam int REG_BYTES = 1 << ADDR_W;
  localparam int RAM_BYTES = REG_BYTES - TIME_BYTES;
  localparam int TB_IW     = $clog2(TIME_BYTES);
  localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(TIME_BYTES);

  logic [7:0] shadow_q [TIME_BYTES];
  logic [7:0] ram_q    [RAM_BYTES];
  logic [ADDR_W-1:0] wr_idx;
  logic [ADDR_W-1:0] rd_idx;

  assign wr_idx = wr_addr - TIME_END;
  assign rd_idx = rd_addr - TIME_END;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TIME_BYTES; k++) shadow_q[k] <= '0;
    end else if (snap_en) begin
      for (int k = 0; k < TIME_BYTES; k++) shadow_q[k] <= time_i[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < RAM_BYTES; k++) ram_q[k] <= '0;
    end else if (wr_en && (wr_addr >= TIME_END)) begin
      ram_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr < TIME_END) rd_data = shadow_q[rd_addr[TB_IW-1:0]];
    else                    rd_data = ram_q[rd_idx];
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h68,
  parameter int         ADDR_W      = 6,
  parameter int         TIME_BYTES  = 7,
  parameter int         SYNC_STAGES = 2,
  parameter int         REC_CYCLES  = 2000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic                    pwr_good_i,
  input  logic [TIME_BYTES*8-1:0] time_i,
  output logic                    wr_valid_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]       wr_data_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic acc_ok;

  xfer_st_e          st_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q;
  logic              first_q;
  logic              nack_q;
  logic              drive_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              wr_valid_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic [BYTE_W-1:0] rd_data;

  logic ev_ok, rx_done, tx_done, ptr_inc, wrap_evt, snap_en;

  i2c_rf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rf_pwr_gate #(.REC_CYCLES(REC_CYCLES)) u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .acc_ok     (acc_ok)
  );

  // Pointer movement happens at the SCL fall that closes a data byte.
  assign ev_ok    = acc_ok && !start_det && !stop_det;
  assign rx_done  = (st_q == ST_RX) && (bit_cnt_q == LAST_BIT) && scl_fall;
  assign tx_done  = (st_q == ST_TX) && (bit_cnt_q == LAST_BIT) && scl_fall;
  assign ptr_inc  = ev_ok && ((rx_done && !first_q) || tx_done);
  assign wrap_evt = ptr_inc && (ptr_q == '1);
  assign snap_en  = start_det || stop_det || wrap_evt;

  i2c_rf_store #(.ADDR_W(ADDR_W), .TIME_BYTES(TIME_BYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_en (snap_en),
    .time_i  (time_i),
    .wr_en   (wr_valid_q),
    .wr_addr (wr_addr_q),
    .wr_data (wr_data_q),
    .rd_addr (ptr_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      nack_q     <= 1'b0;
      drive_q    <= 1'b0;
      ptr_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      if (!acc_ok) begin
        st_q    <= ST_IDLE;
        drive_q <= 1'b0;
      end else if (start_det) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        drive_q   <= 1'b0;
      end else if (stop_det) begin
        st_q    <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (sh_q[BYTE_W-1:1] == SLAVE_ADDR) begin
                st_q    <= ST_AACK;
                rw_q    <= sh_q[0];
                drive_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                st_q    <= ST_TX;
                sh_q    <= rd_data;
                drive_q <= ~rd_data[BYTE_W-1];
              end else begin
                st_q    <= ST_RX;
                first_q <= 1'b1;
                drive_q <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (rx_done) begin
              st_q    <= ST_RACK;
              drive_q <= 1'b1;
              if (first_q) begin
                ptr_q   <= sh_q[ADDR_W-1:0];
                first_q <= 1'b0;
              end else begin
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr_q;
                wr_data_q  <= sh_q;
                ptr_q      <= ptr_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              st_q      <= ST_RX;
              bit_cnt_q <= '0;
              drive_q   <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (tx_done) begin
              st_q    <= ST_MACK;
              drive_q <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
            end else if (scl_fall) begin
              sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
              drive_q <= ~sh_q[BYTE_W-2];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (!nack_q) begin
                st_q      <= ST_TX;
                bit_cnt_q <= '0;
                sh_q      <= rd_data;
                drive_q   <= ~rd_data[BYTE_W-1];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o   = drive_q && acc_ok;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good_i,
  input logic              sda_oe_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det
);
  logic [ADDR_W-1:0] last_a_q;
  logic              have_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_a_q    <= '0;
    end else if (start_det || stop_det) begin
      have_last_q <= 1'b0;
    end else if (wr_valid_o) begin
      have_last_q <= 1'b1;
      last_a_q    <= wr_addr_o;
    end
  end

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R5
  wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && have_last_q) |-> (wr_addr_o == last_a_q + 1'b1));

  // R9
  pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> !wr_valid_o);

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good_i)
    (scl_s && $past(scl_s) && $past(pwr_good_i)) |-> $stable(sda_oe_o));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good_i (pwr_good_i),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det)
);

// File: tb/i2c_regfile_slave_tb_top.sv
module i2c_regfile_slave_tb_top;
  localparam int ADDR_W = 6;
  localparam int TIME_BYTES = 7;
  localparam int REC = 400;
  localparam int Q = 5;
  localparam int NREG = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pwr_good = 1'b1;
  logic [TIME_BYTES*8-1:0] time_v = '0;
  logic sda_oe, wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  i2c_regfile_slave #(.ADDR_W(ADDR_W), .TIME_BYTES(TIME_BYTES), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pwr_good_i(pwr_good), .time_i(time_v), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  logic [7:0] mem_m [NREG];
  logic [ADDR_W-1:0] wlog_a [512];
  logic [7:0] wlog_d [512];

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_cnt < 512) begin
      wlog_a[wr_cnt] = wr_addr;
      wlog_d[wr_cnt] = wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  function automatic logic [7:0] tbyte(input logic [TIME_BYTES*8-1:0] t, input int k);
    return t[k*8 +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [TIME_BYTES*8-1:0] snap;
    int base;
    for (int i = 0; i < NREG; i++) mem_m[i] = 8'h00;

    // reset state
    wq(3);
    chk(sda_oe == 1'b0, "R11 sda in reset", int'(sda_oe), 0);
    chk(wr_valid == 1'b0, "R11 wr_valid in reset", int'(wr_valid), 0);
    rst_n = 1'b1;
    wq(REC + 10);
    chk(sda_oe == 1'b0, "R11 sda after reset", int'(sda_oe), 0);

    // address sweep: each single-bit flip of the target address, then the real one
    for (int k = 0; k < 8; k++) begin
      logic [6:0] a;
      a = (k == 7) ? 7'h68 : (7'h68 ^ (7'h01 << k));
      i2c_start();
      send_byte({a, 1'b0}, ack);
      chk(ack == (k == 7), "R1 address ack", int'(ack), int'(k == 7));
      if (k != 7) begin
        send_byte(8'h00, ack);
        chk(!ack, "R1 released after mismatch", int'(ack), 0);
      end
      i2c_stop();
    end
    chk(wr_cnt == 0, "R1 no write on address only", wr_cnt, 0);

    // 64-byte write from pointer 5, pointer byte carries junk upper bits
    time_v = 56'h11_22_33_44_55_66_77;
    i2c_start();
    send_byte(8'hD0, ack);
    send_byte(8'hC5, ack);
    chk(ack, "R2 pointer byte ack", int'(ack), 1);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) & 255);
      send_byte(d, ack);
      chk(ack, "R2 data ack", int'(ack), 1);
      mem_m[(5 + i) % NREG] = d;
    end
    i2c_stop();
    chk(wr_cnt == NREG, "R2 write count", wr_cnt, NREG);
    for (int i = 0; i < NREG; i++) begin
      chk(int'(wlog_a[i]) == (5 + i) % NREG, "R5 write address order", int'(wlog_a[i]), (5 + i) % NREG);
      chk(int'(wlog_d[i]) == ((i * 37 + 11) & 255), "R2 write data", int'(wlog_d[i]), (i * 37 + 11) & 255);
    end

    // set pointer 0, repeated START, read all 64 bytes while time moves
    i2c_start();
    send_byte(8'hD0, ack);
    send_byte(8'h00, ack);
    i2c_start();
    snap = time_v;
    send_byte(8'hD1, ack);
    chk(ack, "R8 read address after repeated start", int'(ack), 1);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] e;
      if (i == 3) time_v = ~time_v;
      recv_byte(i != NREG - 1, rb);
      e = (i < TIME_BYTES) ? tbyte(snap, i) : mem_m[i];
      chk(rb == e, "R4 R6 read sweep", int'(rb), int'(e));
    end
    chk(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);
    i2c_stop();

    // read with no pointer write: starts at 0 after the wrap
    time_v = 56'h0A_0B_0C_0D_0E_0F_10;
    i2c_start();
    send_byte(8'hD1, ack);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, rb);
      chk(rb == tbyte(time_v, i), "R3 implicit pointer read", int'(rb), int'(tbyte(time_v, i)));
    end
    i2c_stop();
    time_v = 56'h21_32_43_54_65_76_87;
    i2c_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b0, rb);
    chk(rb == tbyte(time_v, 3), "R3 pointer kept across stop", int'(rb), int'(tbyte(time_v, 3)));
    i2c_stop();

    // wrap snapshot: time changes before the pointer rolls to 0
    i2c_start();
    send_byte(8'hD0, ack);
    send_byte(8'h3E, ack);
    i2c_stop();
    time_v = 56'hA1_A2_A3_A4_A5_A6_A7;
    i2c_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b1, rb);
    chk(rb == mem_m[62], "R4 byte 62", int'(rb), int'(mem_m[62]));
    time_v = 56'hB1_B2_B3_B4_B5_B6_B7;
    recv_byte(1'b1, rb);
    chk(rb == mem_m[63], "R5 byte 63", int'(rb), int'(mem_m[63]));
    recv_byte(1'b1, rb);
    chk(rb == tbyte(time_v, 0), "R6 snapshot on wrap", int'(rb), int'(tbyte(time_v, 0)));
    recv_byte(1'b0, rb);
    chk(rb == tbyte(time_v, 1), "R6 snapshot on wrap b1", int'(rb), int'(tbyte(time_v, 1)));
    i2c_stop();

    // next transfer after a nack works
    i2c_start();
    send_byte(8'hD0, ack);
    chk(ack, "R7 ack after nacked read", int'(ack), 1);
    send_byte(8'h20, ack);
    send_byte(8'h5A, ack);
    mem_m[32] = 8'h5A;
    i2c_stop();

    // clocks after STOP with no START are ignored
    base = wr_cnt;
    scl_m = 1'b0; wq(Q);
    send_byte(8'hA5, ack);
    chk(!ack, "R10 no ack without start", int'(ack), 0);
    scl_m = 1'b1; wq(Q);
    chk(wr_cnt == base, "R10 no write without start", wr_cnt, base);
    i2c_start();
    send_byte(8'hD0, ack);
    send_byte(8'h20, ack);
    i2c_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b0, rb);
    chk(rb == 8'h5A, "R10 stray byte not stored", int'(rb), 'h5A);
    i2c_stop();

    // power gating
    base = wr_cnt;
    pwr_good = 1'b0; wq(5);
    i2c_start();
    send_byte(8'hD0, ack);
    chk(!ack, "R9 no ack while power low", int'(ack), 0);
    send_byte(8'h10, ack);
    i2c_stop();
    chk(wr_cnt == base, "R9 no write while power low", wr_cnt, base);
    pwr_good = 1'b1;
    i2c_start();
    send_byte(8'hD0, ack);
    chk(!ack, "R9 no ack during recovery", int'(ack), 0);
    i2c_stop();
    wq(REC);
    i2c_start();
    send_byte(8'hD0, ack);
    chk(ack, "R9 ack after recovery", int'(ack), 1);
    send_byte(8'h21, ack);
    send_byte(8'h77, ack);
    mem_m[33] = 8'h77;
    pwr_good = 1'b0; wq(3);
    pwr_good = 1'b1;
    send_byte(8'h88, ack);
    chk(!ack, "R9 transfer abandoned", int'(ack), 0);
    chk(wr_cnt == base + 1, "R9 one write only", wr_cnt, base + 1);
    i2c_stop();
    wq(REC + 10);
    i2c_start();
    send_byte(8'hD0, ack);
    send_byte(8'h21, ack);
    i2c_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b1, rb);
    chk(rb == 8'h77, "R9 byte before drop kept", int'(rb), 'h77);
    recv_byte(1'b0, rb);
    chk(rb == mem_m[34], "R9 byte after drop untouched", int'(rb), int'(mem_m[34]));
    i2c_stop();

    wq(20);
    finish_run();
  end
endmodule